// File: doc/BRIEF.md
# Burst Scrambler with Preamble Insertion

This block frames one burst of a bit-serial transmit stream. Raising `tx_en` starts a burst. The block first sends a programmable preamble of 0 to 96 bits, which is not scrambled. It then passes the payload bits and XORs each one with a pseudo-random sequence from an additive scrambler. The scrambler offers two polynomials, x^6+x^5+1 and x^15+x^14+1. At the start of every burst it reloads a programmable seed. Lowering `tx_en` ends the burst, and the block then neither accepts nor produces bits.

Data moves over valid/ready streams. A bit moves on a stream in any cycle where valid and ready are both high. A source that raises valid must hold the valid and the bit until ready is seen. While the preamble is being sent, the block holds its output valid and bit stable under back-pressure. During the payload the scrambler is a combinational pass-through, so output ready is passed straight to input ready.

A routing mux lets the scrambler sit in front of or behind an adjacent forward error correction stage. That stage is reached over its own pair of streams: `fec_tx_*` goes to the stage and `fec_rx_*` comes back from it.

Top module: `brs_burst_scrambler`

## Requirements
- R1: While `rst_n` is low and after its release with `tx_en` low, `snk_valid` and `src_ready` are 0.
- R2: A burst with latched preamble length L (1..96) first emits L bits taken from `pre_pattern[L-1]` down to `pre_pattern[0]`, without scrambling. During those bits `src_ready` is 0. Under back-pressure the valid and the bit are held.
- R3: A latched length of 0 starts the payload in the first active cycle. A length above 96 is treated as 96.
- R4: With `poly_sel`=0, the scrambler state s is 6 bits and is loaded from `seed[5:0]`. The mask bit is s[5]^s[4]. After each payload transfer the state becomes {s[4:0], s[5]^s[4]}.
- R5: With `poly_sel`=1, the state s is 15 bits and is loaded from `seed[14:0]`. The mask bit is s[14]^s[13]. After each payload transfer the state becomes {s[13:0], s[14]^s[13]}.
- R6: A burst starts when `tx_en` is seen high at an edge after being low at the previous edge. In the cycle of that edge no bit is offered. The seed, `rand_en`, `poly_sel`, `order_sel` and `pre_len` are latched at that edge and hold until the next burst start.
- R7: With the latched `rand_en`=0, payload bits pass through unchanged.
- R8: During the payload, the scrambler input ready equals its output ready and its output valid equals its input valid. The state advances only on a transfer.
- R9: While `tx_en` is low, the scrambler offers no bit and accepts none.
- R10: With `order_sel`=0 the path is src → scrambler → `fec_tx`, then `fec_rx` → snk. With `order_sel`=1 the path is src → `fec_tx`, then `fec_rx` → scrambler → snk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Burst frame; a rising level starts a burst |
| rand_en | input | 1 | Scrambling enable, latched at burst start |
| poly_sel | input | 1 | 0: x^6+x^5+1, 1: x^15+x^14+1 |
| order_sel | input | 1 | 0: scrambler before FEC, 1: after FEC |
| seed | input | 15 | Scrambler seed (low 6 bits in short mode) |
| pre_len | input | 7 | Preamble length in bits |
| pre_pattern | input | 96 | Preamble content, bit L-1 first |
| src_valid | input | 1 | Upstream bit valid |
| src_ready | output | 1 | Upstream bit accepted |
| src_bit | input | 1 | Upstream bit |
| snk_valid | output | 1 | Downstream bit valid |
| snk_ready | input | 1 | Downstream ready |
| snk_bit | output | 1 | Downstream bit |
| fec_tx_valid | output | 1 | Valid toward FEC stage |
| fec_tx_ready | input | 1 | Ready from FEC stage |
| fec_tx_bit | output | 1 | Bit toward FEC stage |
| fec_rx_valid | input | 1 | Valid from FEC stage |
| fec_rx_ready | output | 1 | Ready toward FEC stage |
| fec_rx_bit | input | 1 | Bit from FEC stage |

## Verification
Two events can land in the same cycle: the last preamble bit moving out, and the sink stalling or the source bringing its first payload bit. The question is whether the handover takes the payload exactly one cycle after the last preamble transfer, with no bit dropped and no mask step lost. The bench drives random ready and valid patterns on every cycle, so the handover meets stalls as well as instant acceptance. The preamble lengths used include 0, 1, 96 and over 96. A bench model walks the preamble index and the scrambler state only on observed transfers, and it compares each bit that arrives at the sink.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam int SHORT_LEN = 6;
  localparam int LONG_LEN  = 15;

  typedef enum logic {
    POLY_SHORT = 1'b0,
    POLY_LONG  = 1'b1
  } poly_e;

  typedef enum logic {
    ORD_SCR_FIRST = 1'b0,
    ORD_FEC_FIRST = 1'b1
  } order_e;
endpackage

// File: rtl/brs_lfsr.sv
module brs_lfsr #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [WIDTH-1:0] seed,
  output logic             mask,
  output logic [WIDTH-1:0] state
);
  // taps at x^WIDTH and x^(WIDTH-1)
  assign mask = state[WIDTH-1] ^ state[WIDTH-2];

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= '0;
    else if (load) state <= seed;
    else if (adv)  state <= {state[WIDTH-2:0], mask};
  end

  // R6
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> state == $past(seed));

  // R8
  hold_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(state));
endmodule

// File: rtl/brs_preamble.sv
module brs_preamble #(
  parameter int PRE_MAX = 96,
  parameter int CW      = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CW-1:0]      len,
  input  logic               adv,
  input  logic [PRE_MAX-1:0] pattern,
  output logic               busy,
  output logic               pbit
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] idx;
  logic [CW-1:0] len_clamped;

  assign len_clamped = (len > CW'(PRE_MAX)) ? CW'(PRE_MAX) : len;
  assign busy = (cnt != '0);
  assign idx  = cnt - CW'(1);
  assign pbit = busy ? pattern[idx] : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (start)         cnt <= len_clamped;
    else if (adv && busy)   cnt <= cnt - CW'(1);
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(PRE_MAX));

  // R2
  one_bit_per_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && busy && !start) |=> cnt == $past(cnt) - CW'(1));
endmodule

// File: rtl/brs_route.sv
module brs_route
  import brs_pkg::*;
(
  input  order_e order,
  input  logic   src_valid,
  output logic   src_ready,
  input  logic   src_bit,
  output logic   snk_valid,
  input  logic   snk_ready,
  output logic   snk_bit,
  output logic   fec_tx_valid,
  input  logic   fec_tx_ready,
  output logic   fec_tx_bit,
  input  logic   fec_rx_valid,
  output logic   fec_rx_ready,
  input  logic   fec_rx_bit,
  output logic   core_in_valid,
  input  logic   core_in_ready,
  output logic   core_in_bit,
  input  logic   core_out_valid,
  output logic   core_out_ready,
  input  logic   core_out_bit
);
  always_comb begin
    if (order == ORD_SCR_FIRST) begin
      core_in_valid  = src_valid;
      core_in_bit    = src_bit;
      src_ready      = core_in_ready;
      fec_tx_valid   = core_out_valid;
      fec_tx_bit     = core_out_bit;
      core_out_ready = fec_tx_ready;
      snk_valid      = fec_rx_valid;
      snk_bit        = fec_rx_bit;
      fec_rx_ready   = snk_ready;
    end else begin
      fec_tx_valid   = src_valid;
      fec_tx_bit     = src_bit;
      src_ready      = fec_tx_ready;
      core_in_valid  = fec_rx_valid;
      core_in_bit    = fec_rx_bit;
      fec_rx_ready   = core_in_ready;
      snk_valid      = core_out_valid;
      snk_bit        = core_out_bit;
      core_out_ready = snk_ready;
    end
  end
endmodule

// File: rtl/brs_burst_scrambler.sv
module brs_burst_scrambler
  import brs_pkg::*;
#(
  parameter int PRE_MAX = 96,
  parameter int LEN_W   = $clog2(PRE_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic               rand_en,
  input  logic               poly_sel,
  input  logic               order_sel,
  input  logic [14:0]        seed,
  input  logic [LEN_W-1:0]   pre_len,
  input  logic [PRE_MAX-1:0] pre_pattern,
  input  logic               src_valid,
  output logic               src_ready,
  input  logic               src_bit,
  output logic               snk_valid,
  input  logic               snk_ready,
  output logic               snk_bit,
  output logic               fec_tx_valid,
  input  logic               fec_tx_ready,
  output logic               fec_tx_bit,
  input  logic               fec_rx_valid,
  output logic               fec_rx_ready,
  input  logic               fec_rx_bit
);
  logic   tx_q, start, active;
  logic   ren_q;
  poly_e  poly_q;
  order_e order_q;

  logic core_in_valid, core_in_ready, core_in_bit;
  logic core_out_valid, core_out_ready, core_out_bit;
  logic pre_busy, pre_bit, pre_adv, pay_xfer;
  logic mask_s, mask_l, mask;
  logic [SHORT_LEN-1:0] st_s;
  logic [LONG_LEN-1:0]  st_l;

  assign start  = tx_en & ~tx_q;
  assign active = tx_en & tx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q    <= 1'b0;
      ren_q   <= 1'b0;
      poly_q  <= POLY_SHORT;
      order_q <= ORD_SCR_FIRST;
    end else begin
      tx_q <= tx_en;
      if (start) begin
        ren_q   <= rand_en;
        poly_q  <= poly_e'(poly_sel);
        order_q <= order_e'(order_sel);
      end
    end
  end

  brs_preamble #(.PRE_MAX(PRE_MAX), .CW(LEN_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .start(start), .len(pre_len),
    .adv(pre_adv), .pattern(pre_pattern), .busy(pre_busy), .pbit(pre_bit)
  );

  brs_lfsr #(.WIDTH(SHORT_LEN)) u_lfsr_s (
    .clk(clk), .rst_n(rst_n), .load(start),
    .adv(pay_xfer && ren_q && poly_q == POLY_SHORT),
    .seed(seed[SHORT_LEN-1:0]), .mask(mask_s), .state(st_s)
  );

  brs_lfsr #(.WIDTH(LONG_LEN)) u_lfsr_l (
    .clk(clk), .rst_n(rst_n), .load(start),
    .adv(pay_xfer && ren_q && poly_q == POLY_LONG),
    .seed(seed[LONG_LEN-1:0]), .mask(mask_l), .state(st_l)
  );

  assign mask = ren_q & ((poly_q == POLY_LONG) ? mask_l : mask_s);

  assign core_out_valid = active & (pre_busy | core_in_valid);
  assign core_out_bit   = pre_busy ? pre_bit : (core_in_bit ^ mask);
  assign core_in_ready  = active & ~pre_busy & core_out_ready;
  assign pre_adv        = active & pre_busy & core_out_ready;
  assign pay_xfer       = active & ~pre_busy & core_in_valid & core_out_ready;

  brs_route u_route (
    .order(order_q),
    .src_valid(src_valid), .src_ready(src_ready), .src_bit(src_bit),
    .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_bit(snk_bit),
    .fec_tx_valid(fec_tx_valid), .fec_tx_ready(fec_tx_ready), .fec_tx_bit(fec_tx_bit),
    .fec_rx_valid(fec_rx_valid), .fec_rx_ready(fec_rx_ready), .fec_rx_bit(fec_rx_bit),
    .core_in_valid(core_in_valid), .core_in_ready(core_in_ready), .core_in_bit(core_in_bit),
    .core_out_valid(core_out_valid), .core_out_ready(core_out_ready), .core_out_bit(core_out_bit)
  );

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (!core_out_valid && !core_in_ready));

  // R2
  pre_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pre_busy && !core_out_ready) |=>
      (!tx_en || (core_out_valid && $stable(core_out_bit))));

  // R2
  pre_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_busy && !start) |=> ($stable(st_s) && $stable(st_l)));

  // R6
  first_cycle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !core_out_valid);
endmodule

// File: tb/test_brs_burst_scrambler.sv
module test_brs_burst_scrambler;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, rand_en = 1'b0, poly_sel = 1'b0, order_sel = 1'b0;
  logic [14:0] seed = '0;
  logic [6:0]  pre_len = '0;
  logic [95:0] pre_pattern = '0;
  logic src_valid = 1'b0, src_bit = 1'b0, snk_ready = 1'b0;
  logic src_ready, snk_valid, snk_bit;
  logic fec_tx_valid, fec_tx_ready, fec_tx_bit;
  logic fec_rx_valid, fec_rx_ready, fec_rx_bit;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  // stand-in FEC stage: inverts every bit
  assign fec_rx_valid = fec_tx_valid;
  assign fec_rx_bit   = ~fec_tx_bit;
  assign fec_tx_ready = fec_rx_ready;

  brs_burst_scrambler i_brs_burst_scrambler (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rand_en(rand_en),
    .poly_sel(poly_sel), .order_sel(order_sel), .seed(seed),
    .pre_len(pre_len), .pre_pattern(pre_pattern),
    .src_valid(src_valid), .src_ready(src_ready), .src_bit(src_bit),
    .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_bit(snk_bit),
    .fec_tx_valid(fec_tx_valid), .fec_tx_ready(fec_tx_ready), .fec_tx_bit(fec_tx_bit),
    .fec_rx_valid(fec_rx_valid), .fec_rx_ready(fec_rx_ready), .fec_rx_bit(fec_rx_bit)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic mask_of(logic [14:0] s, logic long_m);
    return long_m ? (s[14] ^ s[13]) : (s[5] ^ s[4]);
  endfunction

  function automatic logic [14:0] step(logic [14:0] s, logic long_m);
    if (long_m) return {s[13:0], s[14] ^ s[13]};
    return {9'd0, s[4:0], s[5] ^ s[4]};
  endfunction

  task automatic run_burst(input int len, input logic [95:0] pat, input logic poly,
                           input logic [14:0] sd, input logic ren, input logic ord,
                           input int npay, input int rdy_pct, input int vld_pct);
    int eff, pi, sent, guard;
    logic [14:0] ms;
    logic expb;
    string pre_tag, pay_tag;
    eff = (len > 96) ? 96 : len;
    pi = eff;
    sent = 0;
    guard = 0;
    ms = poly ? sd : {9'd0, sd[5:0]};
    pre_tag = (len > 96) ? "R3" : (ord ? "R10" : "R2");
    pay_tag = !ren ? "R7" : (poly ? "R5" : "R4");
    if (eff == 0) pay_tag = {pay_tag, "/R3"};
    @(negedge clk);
    tx_en = 1'b1; rand_en = ren; poly_sel = poly; order_sel = ord;
    seed = sd; pre_len = 7'(len); pre_pattern = pat;
    src_valid = 1'b1; snk_ready = 1'b1;
    #1;
    chk(snk_valid, 1'b0, "R6 start cycle silent");
    // change config after the start edge: must not matter (R6)
    @(posedge clk);
    #1;
    rand_en = ~ren; poly_sel = ~poly; seed = ~sd; pre_len = 7'd3;
    while ((pi > 0 || sent < npay) && guard < 4000) begin
      guard++;
      @(negedge clk);
      src_valid = ($urandom_range(99) < vld_pct);
      src_bit   = 1'($urandom);
      snk_ready = ($urandom_range(99) < rdy_pct);
      #1;
      if (pi > 0) begin
        chk(src_ready, 1'b0, "R2 no intake during preamble");
        chk(snk_valid, 1'b1, {pre_tag, " preamble valid"});
        if (snk_ready) begin
          expb = ord ? pat[pi-1] : ~pat[pi-1];
          chk(snk_bit, expb, {pre_tag, " preamble bit"});
          pi--;
        end
      end else begin
        chk(src_ready, snk_ready, "R8 ready passthrough");
        chk(snk_valid, src_valid, "R8 valid passthrough");
        if (src_valid && snk_ready) begin
          expb = ~src_bit ^ (ren & mask_of(ms, poly));
          chk(snk_bit, expb, {pay_tag, " payload bit"});
          if (ord) chk(fec_tx_bit, src_bit, "R10 fec sees raw source");
          if (ren) ms = step(ms, poly);
          sent++;
        end
      end
    end
    @(negedge clk);
    tx_en = 1'b0; src_valid = 1'b1; snk_ready = 1'b1;
    #1;
    chk(snk_valid, 1'b0, "R9 idle no output");
    chk(src_ready, 1'b0, "R9 idle no intake");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    src_valid = 1'b1; snk_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(snk_valid, 1'b0, "R1 reset snk_valid");
    chk(src_ready, 1'b0, "R1 reset src_ready");
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(snk_valid, 1'b0, "R1 after reset snk_valid");
    chk(src_ready, 1'b0, "R1 after reset src_ready");

    // directed corners
    run_burst(5, 96'h15, 1'b0, 15'h2B, 1'b1, 1'b0, 40, 100, 100);
    run_burst(5, 96'h15, 1'b0, 15'h2B, 1'b1, 1'b0, 40, 60, 70);   // same seed: reload R6
    run_burst(0, '0, 1'b1, 15'h4A5D, 1'b1, 1'b0, 60, 70, 80);
    run_burst(1, 96'h1, 1'b1, 15'h7FFF, 1'b1, 1'b1, 30, 50, 50);
    run_burst(96, {32'hDEADBEEF, 32'h0F0F1234, 32'h8000_0001}, 1'b0, 15'h3F, 1'b1, 1'b1, 20, 60, 60);
    run_burst(120, {3{32'hA5C3_9617}}, 1'b1, 15'h1234, 1'b1, 1'b0, 20, 80, 80);
    run_burst(8, 96'hC3, 1'b1, 15'h5555, 1'b0, 1'b0, 40, 70, 70);
    run_burst(3, 96'h5, 1'b0, 15'h11, 1'b0, 1'b1, 30, 70, 70);

    // constrained random bursts
    for (int b = 0; b < 24; b++) begin
      logic [95:0] p;
      p = {$urandom, $urandom, $urandom};
      run_burst($urandom_range(110), p, 1'($urandom), 15'($urandom),
                ($urandom_range(3) != 0), 1'($urandom),
                $urandom_range(80, 10), $urandom_range(95, 30), $urandom_range(95, 30));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule